// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Staggered Bank Commands

This block produces the auto-refresh work of an SDRAM controller. A reload counter creates one refresh request every 16·I clocks, where I is a 16-bit interval setting. A software test bit can add single requests on top of these. Requests are held as tokens in an eight-entry pending queue. The block services one token at a time. Servicing a token means sending a REF strobe to each installed module bank. The strobes for successive banks are spaced by a programmable stagger, so the current surges of the banks do not line up.

When fewer than eight tokens are waiting, the scheduler raises a request to the command arbiter. It starts a refresh only in a cycle where the arbiter reports an idle slot. With a full queue it marks the request urgent and starts without waiting for that slot. A token that arrives when no room is left is dropped, and a sticky overflow flag records the loss.

Top module: `refresh_sched`

## Requirements
- R1: With interval I ≠ 0, a periodic request is generated P = 16·I clocks after the cycle in which the interval leaves zero, and then every P clocks.
- R2: While the interval is 0, no periodic requests are generated, and the period restarts from zero when it becomes non-zero.
- R3: A new non-zero interval value changes the period only from the next periodic request, which reloads the counter.
- R4: A 0→1 transition of `cfg_test_refresh` adds exactly one request. Holding it high adds no further requests.
- R5: The queue holds up to 8 pending requests. A periodic request and a test request in the same cycle both enter the queue.
- R6: A request that finds no free entry after that cycle's removal is dropped, and `ref_overflow` rises and stays high until reset.
- R7: With 1 to 7 pending and no refresh running, `ref_req` is high, and a refresh starts only in a cycle with `arb_ready` high. With 8 pending, `ref_urgent` is also high and the refresh starts in that cycle regardless of `arb_ready`.
- R8: With stagger S in 1..16 and B = `cfg_last_bank`+1 installed banks, the refresh strobes `ref_bank_stb[k]` for k = 0..B-1 in ascending order, one per strobe, bank k exactly k·S clocks after bank 0. Bank 0 is strobed in the start cycle.
- R9: With stagger 0, all B installed banks are strobed together in the start cycle.
- R10: A stagger value above 16 acts as 16. The stagger and bank count are captured at the start, and later changes do not affect a running refresh.
- R11: A pending entry is removed in the cycle of the last bank's strobe. `ref_req` stays low while a refresh is in progress.
- R12: During reset and right after it, the outputs are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_interval | input | 16 | Refresh interval I; period is 16·I clocks; 0 disables |
| cfg_stagger | input | 5 | Clocks between strobes to successive banks (0..16, larger acts as 16) |
| cfg_test_refresh | input | 1 | Test bit; each rising edge adds one request |
| cfg_last_bank | input | 2 | Number of installed module banks minus one |
| arb_ready | input | 1 | Arbiter offers an idle command slot this cycle |
| ref_req | output | 1 | Refresh wanted (queue non-empty and sequencer idle) |
| ref_urgent | output | 1 | Refresh request at high priority (queue full) |
| ref_bank_stb | output | 4 | Per-bank REF command strobe |
| ref_overflow | output | 1 | Sticky flag: a request was dropped on a full queue |

## Verification
Two things can fall in the same cycle: a periodic request and a test-bit edge. A third case is an arrival while the queue is full, at the same moment a refresh retires or an urgent refresh starts. The bench keeps its own model of when the next periodic request is due. It raises the test bit exactly in that cycle, so two tokens arrive together. It also keeps a long staggered refresh running while the queue is full, so the arrivals overflow. In each cycle, the request, urgency, strobe and overflow outputs are compared with a behavioural model that counts tokens and sequence timing as plain integers.

// File: rtl/refresh_pkg.sv
// Shared types for the refresh scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package refresh_pkg;
    // Sequencer state: idle, or a staggered refresh in progress
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/refresh_interval_timer.sv
// Periodic refresh tick generator.
// Produces a one-cycle tick every 16*interval clocks. An interval of 0 holds
// the counter at zero. The period is sampled only when the counter reloads.
// Assumes: interval is static or changes are allowed to take effect late.
module refresh_interval_timer #(
    parameter int INTERVAL_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INTERVAL_W-1:0] interval,
    output logic                  tick
);
    localparam int CNT_W = INTERVAL_W + 4;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    logic             enabled;

    assign period  = {interval, 4'b0000};
    assign enabled = (interval != '0);
    assign tick    = enabled && (cnt == CNT_W'(1));

    // Count down; reload on start-up (cnt==0) or on tick (cnt==1)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enabled) begin
            cnt <= '0;
        end else if (cnt <= CNT_W'(1)) begin
            cnt <= period;
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    p_tick_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0) |=> !tick);
endmodule

// File: rtl/refresh_req_queue.sv
// Pending refresh request queue.
// Entries carry no data, so the queue is an occupancy count. It takes up to
// two arrivals per cycle (periodic tick and test-bit rising edge) and one
// removal. Arrivals beyond capacity are dropped and set a sticky flag.
// Assumes: pop is only asserted while the queue is non-empty.
module refresh_req_queue #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       test_lvl,
    input  logic                       pop,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       nonempty,
    output logic                       overflow
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             test_d;
    logic             test_pulse;
    logic [1:0]       push_cnt;
    logic [LVL_W:0]   after_pop;
    logic [LVL_W:0]   sum;
    logic             drop;

    assign test_pulse = test_lvl && !test_d;
    assign push_cnt   = {1'b0, tick} + {1'b0, test_pulse};
    assign full       = (level == LVL_W'(DEPTH));
    assign nonempty   = (level != '0);

    // Occupancy after this cycle's removal and arrivals
    always_comb begin
        after_pop = {1'b0, level} - (LVL_W + 1)'(pop);
        sum       = after_pop + (LVL_W + 1)'(push_cnt);
        drop      = (sum > (LVL_W + 1)'(DEPTH));
    end

    // Remember the test bit for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) test_d <= 1'b0;
        else        test_d <= test_lvl;
    end

    // Update occupancy, saturating at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n)    level <= '0;
        else if (drop) level <= LVL_W'(DEPTH);
        else           level <= sum[LVL_W-1:0];
    end

    // Sticky loss flag
    always_ff @(posedge clk) begin
        if (!rst_n)    overflow <= 1'b0;
        else if (drop) overflow <= 1'b1;
    end

    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_ovf_on_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && tick) |=> overflow);

    p_no_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty);
endmodule

// File: rtl/refresh_bank_seq.sv
// Staggered REF command sequencer.
// Starts a refresh when work is pending and the arbiter grants a slot, or at
// once when the queue is full. It strobes bank 0 in the start cycle and bank k
// k*stagger clocks later. With stagger 0 it strobes every installed bank
// together. It removes the queue entry at the last strobe.
// Assumes: NUM_BANKS >= 2 and a power of two.
module refresh_bank_seq #(
    parameter int NUM_BANKS   = 4,
    parameter int STAGGER_W   = 5,
    parameter int STAGGER_MAX = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         q_nonempty,
    input  logic                         q_full,
    input  logic                         arb_ready,
    input  logic [STAGGER_W-1:0]         stagger,
    input  logic [$clog2(NUM_BANKS)-1:0] last_bank,
    output logic                         ref_req,
    output logic                         ref_urgent,
    output logic [NUM_BANKS-1:0]         bank_stb,
    output logic                         pop
);
    import refresh_pkg::*;

    localparam int BIDX_W = $clog2(NUM_BANKS);

    seq_state_t           state;
    logic [BIDX_W-1:0]    idx;
    logic [BIDX_W-1:0]    b_lat;
    logic [STAGGER_W-1:0] wcnt;
    logic [STAGGER_W-1:0] s_lat;
    logic [STAGGER_W-1:0] s_eff;
    logic                 start;
    logic                 step;
    logic [NUM_BANKS-1:0] inst_now;
    logic [NUM_BANKS-1:0] inst_lat;

    assign s_eff      = (stagger > STAGGER_W'(STAGGER_MAX)) ? STAGGER_W'(STAGGER_MAX) : stagger;
    assign ref_req    = (state == SEQ_IDLE) && q_nonempty;
    assign ref_urgent = ref_req && q_full;
    assign start      = ref_req && (arb_ready || q_full);
    assign step       = (state == SEQ_RUN) && (wcnt == '0);

    // Per-bank installed masks and strobe decode
    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign inst_now[i] = (BIDX_W'(i) <= last_bank);
        assign inst_lat[i] = (BIDX_W'(i) <= b_lat);
        assign bank_stb[i] = (start && ((s_eff == '0) ? inst_now[i] : (i == 0)))
                           || (step && (idx == BIDX_W'(i)));
    end

    // Entry retires on the last strobe of a refresh
    always_comb begin
        pop = 1'b0;
        if (start && ((s_eff == '0) || (last_bank == '0))) pop = 1'b1;
        if (step && (idx == b_lat))                       pop = 1'b1;
    end

    // Sequence state, bank index and stagger countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            idx   <= '0;
            b_lat <= '0;
            wcnt  <= '0;
            s_lat <= '0;
        end else if (start && (s_eff != '0) && (last_bank != '0)) begin
            state <= SEQ_RUN;
            idx   <= BIDX_W'(1);
            b_lat <= last_bank;
            s_lat <= s_eff;
            wcnt  <= s_eff - STAGGER_W'(1);
        end else if (step) begin
            if (idx == b_lat) begin
                state <= SEQ_IDLE;
            end else begin
                idx  <= idx + BIDX_W'(1);
                wcnt <= s_lat - STAGGER_W'(1);
            end
        end else if (state == SEQ_RUN) begin
            wcnt <= wcnt - STAGGER_W'(1);
        end
    end

    p_stb_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN) |-> $onehot0(bank_stb));

    p_stb_installed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN) |-> ((bank_stb & ~inst_lat) == '0));

    p_urgent_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> bank_stb[0]);

    p_quiet_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == SEQ_RUN && !step) |-> !ref_req);
endmodule

// File: rtl/refresh_sched.sv
// Refresh scheduler top: interval timer, pending queue and staggered
// bank sequencer.
// Assumes: the arbiter accepts a REF strobe in any cycle it is driven.
module refresh_sched #(
    parameter int INTERVAL_W  = 16,
    parameter int STAGGER_W   = 5,
    parameter int STAGGER_MAX = 16,
    parameter int NUM_BANKS   = 4,
    parameter int QUEUE_DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [INTERVAL_W-1:0]        cfg_interval,
    input  logic [STAGGER_W-1:0]         cfg_stagger,
    input  logic                         cfg_test_refresh,
    input  logic [$clog2(NUM_BANKS)-1:0] cfg_last_bank,
    input  logic                         arb_ready,
    output logic                         ref_req,
    output logic                         ref_urgent,
    output logic [NUM_BANKS-1:0]         ref_bank_stb,
    output logic                         ref_overflow
);
    localparam int LVL_W = $clog2(QUEUE_DEPTH + 1);

    logic             tick;
    logic             pop;
    logic             q_full;
    logic             q_nonempty;
    logic [LVL_W-1:0] q_level;

    refresh_interval_timer #(.INTERVAL_W(INTERVAL_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (cfg_interval),
        .tick     (tick)
    );

    refresh_req_queue #(.DEPTH(QUEUE_DEPTH)) queue_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .test_lvl (cfg_test_refresh),
        .pop      (pop),
        .level    (q_level),
        .full     (q_full),
        .nonempty (q_nonempty),
        .overflow (ref_overflow)
    );

    refresh_bank_seq #(
        .NUM_BANKS   (NUM_BANKS),
        .STAGGER_W   (STAGGER_W),
        .STAGGER_MAX (STAGGER_MAX)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_nonempty (q_nonempty),
        .q_full     (q_full),
        .arb_ready  (arb_ready),
        .stagger    (cfg_stagger),
        .last_bank  (cfg_last_bank),
        .ref_req    (ref_req),
        .ref_urgent (ref_urgent),
        .bank_stb   (ref_bank_stb),
        .pop        (pop)
    );

    p_urgent_iff_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (q_level == LVL_W'(QUEUE_DEPTH)));
endmodule

// File: tb/refresh_sched_tb_top.sv
// Bench for refresh_sched: behavioural per-cycle model compared every clock.
module refresh_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_interval;
    logic [4:0]  cfg_stagger;
    logic        cfg_test_refresh;
    logic [1:0]  cfg_last_bank;
    logic        arb_ready;
    logic        ref_req;
    logic        ref_urgent;
    logic [3:0]  ref_bank_stb;
    logic        ref_overflow;

    always #2 clk = ~clk;

    refresh_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
        .cfg_stagger(cfg_stagger), .cfg_test_refresh(cfg_test_refresh),
        .cfg_last_bank(cfg_last_bank), .arb_ready(arb_ready),
        .ref_req(ref_req), .ref_urgent(ref_urgent),
        .ref_bank_stb(ref_bank_stb), .ref_overflow(ref_overflow)
    );

    int     n_vec = 0;
    int     n_bad = 0;
    string  cur_req = "R12";
    longint cyc = 0;
    // model state
    int     m_level = 0;
    bit     m_ovf = 0;
    longint m_next = -1;
    bit     m_busy = 0;
    longint m_start = 0;
    int     m_s = 0;
    int     m_b = 0;
    bit     m_prev = 0;

    // One clock: compare outputs, then advance the model
    task automatic step(input bit in_reset);
        int  s_now, b_now, d, k;
        bit  tk, req_e, urg_e, start, pop_e, pulse;
        logic [3:0] stb_e;
        logic [6:0] act, exp_v;
        #1;
        s_now = (cfg_stagger > 16) ? 16 : int'(cfg_stagger);
        b_now = int'(cfg_last_bank) + 1;
        tk    = (cfg_interval != 0) && (m_next == cyc);
        req_e = !m_busy && (m_level > 0);
        urg_e = req_e && (m_level == 8);
        start = req_e && (arb_ready || m_level == 8);
        stb_e = 4'b0; pop_e = 0;
        if (start) begin
            if (s_now == 0) begin stb_e = 4'((1 << b_now) - 1); pop_e = 1; end
            else begin stb_e = 4'b0001; if (b_now == 1) pop_e = 1; end
        end
        if (m_busy) begin
            d = int'(cyc - m_start);
            if (d % m_s == 0) begin
                k = d / m_s;
                stb_e = 4'(1 << k);
                if (k == m_b - 1) pop_e = 1;
            end
        end
        exp_v = {req_e, urg_e, stb_e, m_ovf};
        act   = {ref_req, ref_urgent, ref_bank_stb, ref_overflow};
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s cycle %0d: req/urg/stb/ovf actual %b expected %b",
                     cur_req, cyc, act, exp_v);
        end
        @(posedge clk);
        if (in_reset) begin
            m_level = 0; m_ovf = 0; m_next = -1; m_busy = 0; m_prev = 0;
        end else begin
            if (cfg_interval == 0)      m_next = -1;
            else if (m_next < 0)        m_next = cyc + 16 * longint'(cfg_interval);
            else if (tk)                m_next = cyc + 16 * longint'(cfg_interval);
            if (start && s_now > 0 && b_now > 1) begin
                m_busy = 1; m_start = cyc; m_s = s_now; m_b = b_now;
            end else if (m_busy && pop_e) begin
                m_busy = 0;
            end
            pulse  = cfg_test_refresh && !m_prev;
            m_prev = cfg_test_refresh;
            m_level = m_level - int'(pop_e) + int'(tk) + int'(pulse);
            if (m_level > 8) begin m_level = 8; m_ovf = 1; end
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(0);
    endtask

    task automatic pulse_test(input int hold);
        cfg_test_refresh = 1'b1; run(hold);
        cfg_test_refresh = 1'b0; run(2);
    endtask

    initial begin
        rst_n = 1'b0; cfg_interval = '0; cfg_stagger = 5'd1;
        cfg_test_refresh = 1'b0; cfg_last_bank = 2'd0; arb_ready = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        cur_req = "R12";                       // reset state
        for (int i = 0; i < 3; i++) step(1);
        rst_n = 1'b1;
        run(3);

        cur_req = "R4";                        // edges only, no grant
        pulse_test(1); pulse_test(5); pulse_test(3);
        run(4);
        cur_req = "R7";                        // requests wait for a slot
        run(3);
        arb_ready = 1'b1; run(2);
        arb_ready = 1'b0; run(3);
        cur_req = "R11";
        arb_ready = 1'b1; run(6);

        cur_req = "R8";                        // stagger 3, four banks
        arb_ready = 1'b0; cfg_stagger = 5'd3; cfg_last_bank = 2'd3;
        pulse_test(1); pulse_test(1);
        arb_ready = 1'b1; run(30);
        cfg_stagger = 5'd1; cfg_last_bank = 2'd1;
        pulse_test(1); run(6);

        cur_req = "R9";                        // all banks together
        arb_ready = 1'b0; cfg_stagger = 5'd0; cfg_last_bank = 2'd2;
        pulse_test(1); pulse_test(1);
        arb_ready = 1'b1; run(6);

        cur_req = "R10";                       // clamp and capture
        cfg_stagger = 5'd20; cfg_last_bank = 2'd2;
        pulse_test(1);
        run(5); cfg_stagger = 5'd2; cfg_last_bank = 2'd0;
        run(40);

        cur_req = "R1";                        // periodic at 16*I
        cfg_stagger = 5'd0; cfg_last_bank = 2'd0;
        cfg_interval = 16'd1; run(70);
        cur_req = "R3";
        cfg_interval = 16'd3; run(130);
        cur_req = "R2";
        cfg_interval = 16'd0; run(60);
        cfg_interval = 16'd2; run(50);

        cur_req = "R5";                        // tick and test together
        arb_ready = 1'b0; cfg_interval = 16'd1;
        cfg_stagger = 5'd16; cfg_last_bank = 2'd3;
        for (int i = 0; i < 260; i++) begin
            cfg_test_refresh = (m_next == cyc);
            if (i == 60) cur_req = "R6";
            step(0);
        end
        cfg_test_refresh = 1'b0;
        cur_req = "R7";
        cfg_interval = 16'd0; arb_ready = 1'b1;
        run(450);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule